// File: doc/BRIEF.md
# Wavefront Issue Arbiter

This block chooses, every clock, which resident wavefronts may issue their next instruction on a shared SIMD. Each wavefront slot presents a valid bit, a ready bit, the class of its pending instruction and, for vector ALU work, the precision of that operation. The arbiter runs one round-robin picker per execution class, so up to five instructions of different classes issue in the same cycle. Because a slot shows only one pending instruction, the grants in one cycle always name different wavefronts.

Wavefronts may belong to unrelated kernels. Interleaving them lets one wavefront's stall be covered by work from another. Instructions that need no functional unit are released to every eligible slot at once and take no class slot. A 64-thread wavefront passes through a 16-lane vector datapath in several passes, so a vector ALU grant keeps the unit occupied for a number of clocks that depends on the precision. While the unit is occupied, no further vector ALU grant is made and `valu_busy` is high. Grants are combinational from the inputs and the registered pointers; the pointers and the occupancy counter change on the clock edge.

Top module: `wave_issue_arbiter`

## Requirements
- R1: In any cycle, each of the five class grant vectors (vector ALU, scalar, vector memory, local share, export) has at most one bit set.
- R2: A slot is granted in a class only if it is valid, ready and its class code matches that class. The class codes are 0 vector ALU, 1 scalar/branch/message, 2 vector memory, 3 local share, 4 export/global share and 5 internal. Codes 6 and 7 request nothing.
- R3: No slot is granted in more than one class grant vector in the same cycle.
- R4: Each class has its own pointer, cleared to slot 0. Among the requesting slots, the first one found from the pointer upward, wrapping past the last slot, wins. After a grant to slot k, the pointer moves to k+1, or to 0 after the last slot.
- R5: Invalid or stalled (not ready) slots are skipped. A class with no eligible request grants nothing, and its pointer keeps its value.
- R6: Every valid, ready slot with class 5 (internal) is granted on `grant_internal` in the same cycle. This does not use or block any class grant.
- R7: Precision code 0 (single precision) keeps the vector unit busy for 4 clocks. `valu_busy` is high for the 3 cycles after the grant, and the next vector ALU grant comes no earlier than 4 cycles after the previous one.
- R8: Precision code 1 (double-precision add) occupies the vector unit for 8 clocks, so consecutive vector ALU grants are 8 cycles apart and `valu_busy` is high for 7 of them.
- R9: Precision code 2 or 3 (double-precision multiply, FMA or transcendental) occupies the vector unit for 16 clocks, so consecutive vector ALU grants are 16 cycles apart.
- R10: While `valu_busy` is high, no vector ALU grant is made, and the other classes keep granting as usual.
- R11: Synchronous reset clears all pointers to slot 0 and drops `valu_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | N_SLOTS | Slot holds a resident wavefront |
| slot_ready | input | N_SLOTS | Wavefront's next instruction has no pending stall |
| slot_class | input | 3*N_SLOTS | Class code of each slot's next instruction, slot s at bits 3s+2:3s |
| slot_prec | input | 2*N_SLOTS | Vector ALU precision code per slot, slot s at bits 2s+1:2s |
| grant_valu | output | N_SLOTS | Vector ALU grant, one-hot or zero |
| grant_scalar | output | N_SLOTS | Scalar/branch/message grant, one-hot or zero |
| grant_vmem | output | N_SLOTS | Vector memory grant, one-hot or zero |
| grant_lds | output | N_SLOTS | Local share grant, one-hot or zero |
| grant_export | output | N_SLOTS | Export/global share grant, one-hot or zero |
| grant_internal | output | N_SLOTS | Internal instructions released this cycle |
| valu_busy | output | 1 | Vector unit is occupied by an earlier multi-cycle operation |

## Verification
The hardest situation to reach is a vector ALU grant that is held back by occupancy while other classes keep issuing. To get there, the bench holds a vector request on one slot and a scalar request on another. It then checks, cycle by cycle, that the scalar grants continue while the vector grants pause. It also measures the exact spacing between vector grants for each precision. Pointer wrap and the skipping of stalled slots are reached by sequences of vectors that move each class pointer to a known position before the deciding request.

// File: rtl/wia_pkg.sv
package wia_pkg;

    localparam int CLS_W  = 3;
    localparam int PREC_W = 2;
    localparam int NUM_ARB_CLASSES = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_VALU     = 3'd0,
        CLS_SCALAR   = 3'd1,
        CLS_VMEM     = 3'd2,
        CLS_LDS      = 3'd3,
        CLS_EXPORT   = 3'd4,
        CLS_INTERNAL = 3'd5,
        CLS_RSV6     = 3'd6,
        CLS_RSV7     = 3'd7
    } instr_class_e;

    typedef enum logic [PREC_W-1:0] {
        PREC_SP     = 2'd0,
        PREC_DP_ADD = 2'd1,
        PREC_DP_MUL = 2'd2,
        PREC_DP_XCN = 2'd3
    } valu_prec_e;

    // Clocks the vector unit stays occupied, given passes per single-precision op.
    function automatic int unsigned occupancy_cycles(valu_prec_e p, int unsigned passes);
        case (p)
            PREC_SP:     return passes;
            PREC_DP_ADD: return 2 * passes;
            default:     return 4 * passes;
        endcase
    endfunction

endpackage

// File: rtl/wia_class_decode.sv
module wia_class_decode
    import wia_pkg::*;
#(
    parameter int N_SLOTS = 10
) (
    input  logic [N_SLOTS-1:0]                      slot_valid,
    input  logic [N_SLOTS-1:0]                      slot_ready,
    input  logic [N_SLOTS*CLS_W-1:0]                slot_class,
    output logic [NUM_ARB_CLASSES-1:0][N_SLOTS-1:0] class_req,
    output logic [N_SLOTS-1:0]                      internal_req
);

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        instr_class_e cls;
        logic         eligible;

        assign cls      = instr_class_e'(slot_class[s*CLS_W +: CLS_W]);
        assign eligible = slot_valid[s] & slot_ready[s];

        for (genvar c = 0; c < NUM_ARB_CLASSES; c++) begin : g_cls
            assign class_req[c][s] = eligible && (cls == instr_class_e'(c));
        end

        assign internal_req[s] = eligible && (cls == CLS_INTERNAL);
    end

endmodule

// File: rtl/wia_rr_pick.sv
module wia_rr_pick #(
    parameter int N_SLOTS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SLOTS-1:0] req,
    output logic [N_SLOTS-1:0] gnt
);

    localparam int PW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam logic [PW-1:0] LAST = PW'(N_SLOTS - 1);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] win;
    logic          hit;

    always_comb begin
        gnt = '0;
        win = '0;
        hit = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            int idx;
            idx = int'(ptr_q) + i;
            if (idx >= N_SLOTS) idx = idx - N_SLOTS;
            if (!hit && req[idx]) begin
                hit = 1'b1;
                win = PW'(idx);
            end
        end
        if (hit) gnt[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (hit) begin
            ptr_q <= (win == LAST) ? '0 : win + 1'b1;
        end
    end

endmodule

// File: rtl/wia_valu_occupancy.sv
module wia_valu_occupancy
    import wia_pkg::*;
#(
    parameter int WAVE_SIZE = 64,
    parameter int LANES     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  valu_prec_e prec,
    output logic       busy
);

    localparam int PASSES = WAVE_SIZE / LANES;
    localparam int MAXC   = 4 * PASSES;
    localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= CW'(occupancy_cycles(prec, PASSES) - 1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);

endmodule

// File: rtl/wave_issue_arbiter.sv
module wave_issue_arbiter
    import wia_pkg::*;
#(
    parameter int N_SLOTS   = 10,
    parameter int WAVE_SIZE = 64,
    parameter int LANES     = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_SLOTS-1:0]        slot_valid,
    input  logic [N_SLOTS-1:0]        slot_ready,
    input  logic [N_SLOTS*CLS_W-1:0]  slot_class,
    input  logic [N_SLOTS*PREC_W-1:0] slot_prec,
    output logic [N_SLOTS-1:0]        grant_valu,
    output logic [N_SLOTS-1:0]        grant_scalar,
    output logic [N_SLOTS-1:0]        grant_vmem,
    output logic [N_SLOTS-1:0]        grant_lds,
    output logic [N_SLOTS-1:0]        grant_export,
    output logic [N_SLOTS-1:0]        grant_internal,
    output logic                      valu_busy
);

    logic [NUM_ARB_CLASSES-1:0][N_SLOTS-1:0] class_req;
    logic [NUM_ARB_CLASSES-1:0][N_SLOTS-1:0] arb_req;
    logic [NUM_ARB_CLASSES-1:0][N_SLOTS-1:0] class_gnt;
    logic [N_SLOTS-1:0]                      internal_req;
    valu_prec_e                              sel_prec;

    wia_class_decode #(.N_SLOTS(N_SLOTS)) u_decode (
        .slot_valid   (slot_valid),
        .slot_ready   (slot_ready),
        .slot_class   (slot_class),
        .class_req    (class_req),
        .internal_req (internal_req)
    );

    // The vector class is masked while the unit is still occupied.
    always_comb begin
        arb_req = class_req;
        if (valu_busy) arb_req[CLS_VALU] = '0;
    end

    for (genvar c = 0; c < NUM_ARB_CLASSES; c++) begin : g_arb
        wia_rr_pick #(.N_SLOTS(N_SLOTS)) u_pick (
            .clk (clk),
            .rst (rst),
            .req (arb_req[c]),
            .gnt (class_gnt[c])
        );
    end

    always_comb begin
        sel_prec = PREC_SP;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (class_gnt[CLS_VALU][s]) sel_prec = valu_prec_e'(slot_prec[s*PREC_W +: PREC_W]);
        end
    end

    wia_valu_occupancy #(.WAVE_SIZE(WAVE_SIZE), .LANES(LANES)) u_occ (
        .clk   (clk),
        .rst   (rst),
        .start (|class_gnt[CLS_VALU]),
        .prec  (sel_prec),
        .busy  (valu_busy)
    );

    assign grant_valu     = class_gnt[CLS_VALU];
    assign grant_scalar   = class_gnt[CLS_SCALAR];
    assign grant_vmem     = class_gnt[CLS_VMEM];
    assign grant_lds      = class_gnt[CLS_LDS];
    assign grant_export   = class_gnt[CLS_EXPORT];
    assign grant_internal = internal_req;

endmodule

// File: rtl/wave_issue_arbiter_chk.sv
module wave_issue_arbiter_chk #(
    parameter int N_SLOTS = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_SLOTS-1:0]   slot_valid,
    input logic [N_SLOTS-1:0]   slot_ready,
    input logic [N_SLOTS*3-1:0] slot_class,
    input logic [N_SLOTS-1:0]   grant_valu,
    input logic [N_SLOTS-1:0]   grant_scalar,
    input logic [N_SLOTS-1:0]   grant_vmem,
    input logic [N_SLOTS-1:0]   grant_lds,
    input logic [N_SLOTS-1:0]   grant_export,
    input logic                 valu_busy
);

    AST_ONEHOT_VALU:   assert property (@(posedge clk) disable iff (rst) $onehot0(grant_valu));   // R1
    AST_ONEHOT_SCALAR: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_scalar)); // R1
    AST_ONEHOT_VMEM:   assert property (@(posedge clk) disable iff (rst) $onehot0(grant_vmem));   // R1
    AST_ONEHOT_LDS:    assert property (@(posedge clk) disable iff (rst) $onehot0(grant_lds));    // R1
    AST_ONEHOT_EXPORT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_export)); // R1

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
            (grant_valu[s] | grant_scalar[s] | grant_vmem[s] | grant_lds[s] | grant_export[s])
            |-> (slot_valid[s] && slot_ready[s])); // R2
        AST_VALU_CLASS_MATCH: assert property (@(posedge clk) disable iff (rst)
            grant_valu[s] |-> (slot_class[s*3 +: 3] == 3'd0)); // R2
        AST_DISTINCT_WAVE: assert property (@(posedge clk) disable iff (rst)
            $countones({grant_valu[s], grant_scalar[s], grant_vmem[s], grant_lds[s], grant_export[s]}) <= 1); // R3
    end

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        ((slot_valid & slot_ready) == '0)
        |-> ((grant_valu | grant_scalar | grant_vmem | grant_lds | grant_export) == '0)); // R5
    AST_BUSY_AFTER_VALU: assert property (@(posedge clk) disable iff (rst)
        (|grant_valu) |=> valu_busy); // R7
    AST_NO_VALU_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        valu_busy |-> (grant_valu == '0)); // R10

endmodule

bind wave_issue_arbiter wave_issue_arbiter_chk #(.N_SLOTS(N_SLOTS)) u_wia_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_valid   (slot_valid),
    .slot_ready   (slot_ready),
    .slot_class   (slot_class),
    .grant_valu   (grant_valu),
    .grant_scalar (grant_scalar),
    .grant_vmem   (grant_vmem),
    .grant_lds    (grant_lds),
    .grant_export (grant_export),
    .valu_busy    (valu_busy)
);

// File: tb/test_wave_issue_arbiter.sv
module test_wave_issue_arbiter;

    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] slot_valid = '0;
    logic [N-1:0] slot_ready = '0;
    logic [3*N-1:0] slot_class = '1;
    logic [2*N-1:0] slot_prec  = '0;
    logic [N-1:0] grant_valu, grant_scalar, grant_vmem, grant_lds, grant_export, grant_internal;
    logic         valu_busy;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wave_issue_arbiter i_wave_issue_arbiter (
        .clk            (clk),
        .rst            (rst),
        .slot_valid     (slot_valid),
        .slot_ready     (slot_ready),
        .slot_class     (slot_class),
        .slot_prec      (slot_prec),
        .grant_valu     (grant_valu),
        .grant_scalar   (grant_scalar),
        .grant_vmem     (grant_vmem),
        .grant_lds      (grant_lds),
        .grant_export   (grant_export),
        .grant_internal (grant_internal),
        .valu_busy      (valu_busy)
    );

    // valid, ready, class nibbles (slot 9 leftmost), expected scalar, vmem, lds, export, internal
    typedef struct packed {
        logic [9:0]  v;
        logic [9:0]  r;
        logic [39:0] cls;
        logic [9:0]  es;
        logic [9:0]  em;
        logic [9:0]  el;
        logic [9:0]  ee;
        logic [9:0]  ei;
    } vec_t;

    localparam vec_t TABLE [12] = '{
        '{10'h000, 10'h3FF, 40'h1111111111, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000}, // R5 nothing valid
        '{10'h3FF, 10'h3FF, 40'h1111111111, 10'h001, 10'h000, 10'h000, 10'h000, 10'h000}, // R4
        '{10'h3FF, 10'h3FF, 40'h1111111111, 10'h002, 10'h000, 10'h000, 10'h000, 10'h000}, // R4
        '{10'h3FF, 10'h3FB, 40'h1111111111, 10'h008, 10'h000, 10'h000, 10'h000, 10'h000}, // R5 stalled slot2
        '{10'h204, 10'h3FF, 40'h1111111111, 10'h200, 10'h000, 10'h000, 10'h000, 10'h000}, // R5 invalid skipped
        '{10'h204, 10'h3FF, 40'h1111111111, 10'h004, 10'h000, 10'h000, 10'h000, 10'h000}, // R4 wrap
        '{10'h3FF, 10'h3FF, 40'h7777551432, 10'h008, 10'h001, 10'h002, 10'h004, 10'h030}, // R3 R6 mixed
        '{10'h3FF, 10'h3FF, 40'h2222222222, 10'h000, 10'h002, 10'h000, 10'h000, 10'h000}, // R4 own pointer
        '{10'h3FF, 10'h3FF, 40'h7777777722, 10'h000, 10'h001, 10'h000, 10'h000, 10'h000}, // R4 wrap
        '{10'h3FF, 10'h3FF, 40'h6666666666, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000}, // R2 codes 6
        '{10'h3FF, 10'h001, 40'h3333333333, 10'h000, 10'h000, 10'h001, 10'h000, 10'h000}, // R5 behind pointer
        '{10'h3FF, 10'h3FF, 40'h4444444444, 10'h000, 10'h000, 10'h000, 10'h008, 10'h000}  // R4 export ptr
    };

    task automatic check10(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_all(input logic [2:0] c, input logic [1:0] p);
        for (int s = 0; s < N; s++) begin
            slot_class[s*3 +: 3] = c;
            slot_prec[s*2 +: 2]  = p;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        slot_valid = '0;
        slot_ready = '0;
        set_all(3'd7, 2'd0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Hold one vector request on slot 0 and measure grant spacing and busy cycles.
    task automatic measure_gap(input logic [1:0] p, input int exp_gap, input string tag);
        int first = -1;
        int second = -1;
        int busy_n = 0;
        do_reset();
        slot_class[2:0] = 3'd0;
        slot_prec[1:0]  = p;
        slot_valid = 10'h001;
        slot_ready = 10'h001;
        for (int c = 0; c < 40; c++) begin
            #1;
            if (grant_valu[0]) begin
                if (first < 0) first = c;
                else if (second < 0) second = c;
            end
            if (first >= 0 && second < 0 && valu_busy) busy_n++;
            @(negedge clk);
        end
        check10({tag, " grant gap"}, N'(second - first), N'(exp_gap));
        check10({tag, " busy cycles"}, N'(busy_n), N'(exp_gap - 1));
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R11 reset state
        @(negedge clk);
        @(negedge clk);
        #1;
        check10("R11 busy in reset", N'(valu_busy), '0);
        check10("R11 no grant in reset", grant_valu | grant_scalar | grant_vmem, '0);
        rst = 1'b0;

        // Table walk, one vector per cycle
        foreach (TABLE[k]) begin
            @(negedge clk);
            slot_valid = TABLE[k].v;
            slot_ready = TABLE[k].r;
            for (int s = 0; s < N; s++) slot_class[s*3 +: 3] = TABLE[k].cls[s*4 +: 3];
            #1;
            check10($sformatf("R4 vec%0d scalar", k), grant_scalar, TABLE[k].es);
            check10($sformatf("R4 vec%0d vmem", k), grant_vmem, TABLE[k].em);
            check10($sformatf("R4 vec%0d lds", k), grant_lds, TABLE[k].el);
            check10($sformatf("R4 vec%0d export", k), grant_export, TABLE[k].ee);
            check10($sformatf("R6 vec%0d internal", k), grant_internal, TABLE[k].ei);
            check10($sformatf("R2 vec%0d valu", k), grant_valu, '0);
        end

        // R11 reset returns pointer to slot 0
        @(negedge clk);
        set_all(3'd1, 2'd0);
        slot_valid = '1;
        slot_ready = '1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check10("R11 pointer cleared", grant_scalar, 10'h001);

        // R7 R8 R9 vector occupancy per precision
        measure_gap(2'd0, 4, "R7 single");
        measure_gap(2'd1, 8, "R8 dp add");
        measure_gap(2'd2, 16, "R9 dp mul");
        measure_gap(2'd3, 16, "R9 transcendental");

        // R10 other classes continue while vector unit busy
        do_reset();
        slot_class[2:0] = 3'd0;
        slot_class[5:3] = 3'd1;
        slot_valid = 10'h003;
        slot_ready = 10'h003;
        #1;
        check10("R3 valu and scalar together", grant_valu, 10'h001);
        check10("R3 scalar beside valu", grant_scalar, 10'h002);
        @(negedge clk);
        #1;
        check10("R10 valu held", grant_valu, '0);
        check10("R10 busy high", N'(valu_busy), N'(1));
        check10("R10 scalar still granted", grant_scalar, 10'h002);

        // R4 vector class rotates between two slots
        do_reset();
        slot_class[5:0] = 6'o00;
        slot_valid = 10'h003;
        slot_ready = 10'h003;
        #1;
        check10("R4 valu first", grant_valu, 10'h001);
        repeat (4) @(negedge clk);
        #1;
        check10("R4 valu rotates", grant_valu, 10'h002);

        // R6 all internal at once, no class grant
        do_reset();
        set_all(3'd5, 2'd0);
        slot_valid = '1;
        slot_ready = '1;
        #1;
        check10("R6 internal all", grant_internal, 10'h3FF);
        check10("R6 no class grant", grant_valu | grant_scalar | grant_vmem | grant_lds | grant_export, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule